// File: doc/BRIEF.md
# Filtered Threshold Comparator for Converted Samples

This block watches the stream of converted samples from an analog-to-digital converter. It tests each sample against a programmable low threshold, a programmable high threshold, or both. When enough of these tests in a row report a hit, it raises a compare event flag. The flag stays set until software clears it, and it also drives an interrupt line. A per-channel gate decides which samples are tested. Either a single chosen channel is compared, or every channel is compared.

Thresholds are always programmed at the full 10-bit scale. When the converter runs in its 8-bit resolution mode, the block widens each sample to 10 bits before the test. Software therefore never has to rescale the thresholds. A consecutive-hit filter suppresses isolated outliers: a miss restarts the run, and samples from channels that are not selected neither extend nor break it.

Top module: `cmpwin_top`

## Requirements
- R1: After reset, `cmp_flag` and `cmp_irq` are 0.
- R2: With `cfg_mode` = 0 (below), a compared sample hits when its value is strictly less than `cfg_thr_lo`. A value equal to the threshold does not hit.
- R3: With `cfg_mode` = 1 (above), a compared sample hits when its value is strictly greater than `cfg_thr_hi`. A value equal to the threshold does not hit.
- R4: With `cfg_mode` = 2 or 3 (outside window), a compared sample hits when its value is below `cfg_thr_lo` or above `cfg_thr_hi`. Values from `cfg_thr_lo` to `cfg_thr_hi`, both inclusive, do not hit.
- R5: A sample is compared only when `smp_chan` equals `cfg_chan` or `cfg_all` is 1. A sample that is not compared leaves the consecutive-hit count unchanged.
- R6: A compared sample that misses resets the consecutive-hit count to zero.
- R7: `cmp_flag` rises on the clock edge that samples the (`cfg_filter`+1)th consecutive hit. With `cfg_filter` = 0, a single hit raises it.
- R8: When `lowres` is 1, only `smp_data[7:0]` is used, shifted left by 2, before the comparison. The thresholds are used unchanged.
- R9: `cmp_flag` holds until `flag_clr` is sampled high. It reads 0 after that edge. If a set event occurs in the same cycle as the clear, the set wins.
- R10: `cmp_irq` is always equal to `cmp_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per converted sample |
| smp_data | input | 10 | Sample value; bits 7:0 only in low-resolution mode |
| smp_chan | input | 4 | Channel number of the sample |
| lowres | input | 1 | 1 = 8-bit resolution mode |
| cfg_mode | input | 2 | 0 below, 1 above, 2/3 outside window |
| cfg_chan | input | 4 | Channel compared when `cfg_all` is 0 |
| cfg_all | input | 1 | 1 = compare every channel |
| cfg_filter | input | 4 | Consecutive hits needed, minus one |
| cfg_thr_lo | input | 10 | Low threshold, full scale |
| cfg_thr_hi | input | 10 | High threshold, full scale |
| flag_clr | input | 1 | Read-to-clear strobe for the flag |
| cmp_flag | output | 1 | Sticky compare event flag |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The bench probes samples that sit exactly on each threshold. A design with a non-strict compare would flag them. In low-resolution mode it drives samples whose discarded upper bits would change the result. It also drives samples whose unscaled value lands on the other side of a threshold. An unscaled design, or one that does not mask those bits, gives the wrong answer on these samples. Filter runs check several cases: a flag one hit early or late, a miss that fails to restart the run, and an unselected sample that breaks or extends the run. Each of these faults moves the flag edge. The last test puts a clear in the same cycle as a new hit, which exposes a design where the clear wins.

// File: rtl/cmpwin_pkg.sv
package cmpwin_pkg;
  localparam int FULL_W = 10;
  localparam int LOW_W  = 8;
  localparam int SHIFT  = FULL_W - LOW_W;

  typedef enum logic [1:0] {
    MODE_BELOW  = 2'd0,
    MODE_ABOVE  = 2'd1,
    MODE_OUT_A  = 2'd2,
    MODE_OUT_B  = 2'd3
  } cmp_mode_e;

  // Widen a sample to full scale.
  function automatic logic [FULL_W-1:0] scale_sample(input logic [FULL_W-1:0] raw,
                                                      input logic lowres);
    if (lowres) return {raw[LOW_W-1:0], {SHIFT{1'b0}}};
    return raw;
  endfunction

  // Threshold test for one full-scale value.
  function automatic logic test_hit(input cmp_mode_e mode,
                                    input logic [FULL_W-1:0] v,
                                    input logic [FULL_W-1:0] lo,
                                    input logic [FULL_W-1:0] hi);
    case (mode)
      MODE_BELOW: return v < lo;
      MODE_ABOVE: return v > hi;
      default:    return (v < lo) || (v > hi);
    endcase
  endfunction
endpackage

// File: rtl/cmpwin_scale.sv
module cmpwin_scale
  import cmpwin_pkg::*;
(
  input  logic [FULL_W-1:0] raw,
  input  logic              lowres,
  output logic [FULL_W-1:0] value
);
  always_comb value = scale_sample(raw, lowres);
endmodule

// File: rtl/cmpwin_test.sv
module cmpwin_test
  import cmpwin_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic [1:0]        mode,
  input  logic [FULL_W-1:0] value,
  input  logic [FULL_W-1:0] thr_lo,
  input  logic [FULL_W-1:0] thr_hi,
  input  logic [CH_W-1:0]   chan,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic              all_chan,
  output logic              selected,
  output logic              hit
);
  always_comb begin
    selected = all_chan || (chan == sel_chan);
    hit      = test_hit(cmp_mode_e'(mode), value, thr_lo, thr_hi);
  end
endmodule

// File: rtl/cmpwin_filter.sv
module cmpwin_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              hit,
  input  logic [FILT_W-1:0] filter,
  input  logic              clr,
  output logic              flag,
  output logic [FILT_W:0]   run_cnt,
  output logic              set_evt
);
  localparam int CNT_W = FILT_W + 1;

  logic [CNT_W-1:0] filt_ext;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    filt_ext = {1'b0, filter};
    set_evt  = evt && hit && (run_cnt >= filt_ext);
    cnt_nxt  = run_cnt;
    if (evt) begin
      if (!hit)                 cnt_nxt = '0;
      else if (run_cnt <= filt_ext) cnt_nxt = run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      flag    <= 1'b0;
    end else begin
      run_cnt <= cnt_nxt;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_evt |=> !flag); // R9
  AST_EXCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(run_cnt)); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !hit |=> run_cnt == '0); // R6
  AST_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(evt && hit)); // R7
endmodule

// File: rtl/cmpwin_top.sv
module cmpwin_top
  import cmpwin_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [FULL_W-1:0] smp_data,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic              lowres,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_all,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic [FULL_W-1:0] cfg_thr_lo,
  input  logic [FULL_W-1:0] cfg_thr_hi,
  input  logic              flag_clr,
  output logic              cmp_flag,
  output logic              cmp_irq
);
  logic [FULL_W-1:0] scaled;
  logic              chan_ok;
  logic              is_hit;
  logic              cmp_evt;
  logic [FILT_W:0]   run_cnt;
  logic              set_evt;

  cmpwin_scale u_scale (
    .raw    (smp_data),
    .lowres (lowres),
    .value  (scaled)
  );

  cmpwin_test #(.CH_W(CH_W)) u_test (
    .mode     (cfg_mode),
    .value    (scaled),
    .thr_lo   (cfg_thr_lo),
    .thr_hi   (cfg_thr_hi),
    .chan     (smp_chan),
    .sel_chan (cfg_chan),
    .all_chan (cfg_all),
    .selected (chan_ok),
    .hit      (is_hit)
  );

  assign cmp_evt = smp_valid && chan_ok;

  cmpwin_filter #(.FILT_W(FILT_W)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (cmp_evt),
    .hit     (is_hit),
    .filter  (cfg_filter),
    .clr     (flag_clr),
    .flag    (cmp_flag),
    .run_cnt (run_cnt),
    .set_evt (set_evt)
  );

  assign cmp_irq = cmp_flag;

  AST_LOWRES_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && lowres |-> (scaled >> SHIFT) == FULL_W'(smp_data[LOW_W-1:0])); // R8
  AST_CLR_SET_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && flag_clr |=> cmp_flag); // R9
endmodule

// File: tb/cmpwin_top_tb_top.sv
module cmpwin_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic [3:0] smp_chan = '0;
  logic       lowres = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [3:0] cfg_chan = 4'd3;
  logic       cfg_all = 1'b0;
  logic [3:0] cfg_filter = '0;
  logic [9:0] cfg_thr_lo = 10'd100;
  logic [9:0] cfg_thr_hi = 10'd900;
  logic       flag_clr = 1'b0;
  logic       cmp_flag;
  logic       cmp_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cmpwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .lowres(lowres), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_all(cfg_all), .cfg_filter(cfg_filter), .cfg_thr_lo(cfg_thr_lo),
    .cfg_thr_hi(cfg_thr_hi), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  // {mode[2], all, lowres, chan[4], data[10], expected flag}; cfg_chan=3, lo=100, hi=900
  localparam logic [18:0] VEC [13] = '{
    {2'd0, 1'b0, 1'b0, 4'd3, 10'd99,   1'b1},  // R2 below
    {2'd0, 1'b0, 1'b0, 4'd3, 10'd100,  1'b0},  // R2 equal lo
    {2'd1, 1'b0, 1'b0, 4'd3, 10'd901,  1'b1},  // R3 above
    {2'd1, 1'b0, 1'b0, 4'd3, 10'd900,  1'b0},  // R3 equal hi
    {2'd2, 1'b0, 1'b0, 4'd3, 10'd50,   1'b1},  // R4 under window
    {2'd2, 1'b0, 1'b0, 4'd3, 10'd950,  1'b1},  // R4 over window
    {2'd2, 1'b0, 1'b0, 4'd3, 10'd500,  1'b0},  // R4 inside
    {2'd3, 1'b0, 1'b0, 4'd3, 10'd100,  1'b0},  // R4 edge, mode 3
    {2'd0, 1'b0, 1'b0, 4'd5, 10'd50,   1'b0},  // R5 other channel
    {2'd0, 1'b1, 1'b0, 4'd5, 10'd50,   1'b1},  // R5 all channels
    {2'd0, 1'b0, 1'b1, 4'd3, 10'd25,   1'b0},  // R8 25<<2 = 100
    {2'd0, 1'b0, 1'b1, 4'd3, 10'h318,  1'b1},  // R8 upper bits dropped, 96
    {2'd1, 1'b0, 1'b1, 4'd3, 10'd226,  1'b1}   // R8 226<<2 = 904
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] ch, input logic [9:0] d, input logic clr);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d; flag_clr = clr;
    @(negedge clk);
    smp_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag at reset", cmp_flag, 1'b0);
    check("R1 irq at reset", cmp_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after release", cmp_flag, 1'b0);

    foreach (VEC[i]) begin
      clear_flag();
      cfg_mode = VEC[i][18:17];
      cfg_all  = VEC[i][16];
      lowres   = VEC[i][15];
      send(VEC[i][14:11], VEC[i][10:1], 1'b0);
      check($sformatf("vector %0d flag (R2-R5,R8 table)", i), cmp_flag, VEC[i][0]);
      check("R10 irq follows flag", cmp_irq, cmp_flag);
    end
    cfg_all = 1'b0; lowres = 1'b0; cfg_mode = 2'd0;

    // R9 sticky, then cleared
    clear_flag();
    send(4'd3, 10'd10, 1'b0);
    send(4'd3, 10'd500, 1'b0);
    check("R9 flag holds after miss", cmp_flag, 1'b1);
    clear_flag();
    check("R9 flag cleared", cmp_flag, 1'b0);
    check("R10 irq cleared", cmp_irq, 1'b0);

    // R7 filter=2 needs three hits
    cfg_filter = 4'd2;
    send(4'd3, 10'd10, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R7 two hits not enough", cmp_flag, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R7 third hit raises", cmp_flag, 1'b1);

    // R6 miss restarts run
    send(4'd3, 10'd500, 1'b0);
    clear_flag();
    send(4'd3, 10'd10, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    send(4'd3, 10'd500, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R6 run restarted by miss", cmp_flag, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R6 third hit after miss", cmp_flag, 1'b1);

    // R5 excluded sample keeps count
    send(4'd3, 10'd500, 1'b0);
    clear_flag();
    send(4'd3, 10'd10, 1'b0);
    send(4'd7, 10'd500, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R5 excluded miss ignored, two hits", cmp_flag, 1'b0);
    send(4'd7, 10'd10, 1'b0);
    check("R5 excluded hit not counted", cmp_flag, 1'b0);
    send(4'd3, 10'd10, 1'b0);
    check("R5 run continued across excluded", cmp_flag, 1'b1);

    // R9 set beats clear in the same cycle
    cfg_filter = 4'd0;
    send(4'd3, 10'd10, 1'b1);
    check("R9 set wins over clear", cmp_flag, 1'b1);
    clear_flag();
    check("R9 clear alone", cmp_flag, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule